// File: doc/BRIEF.md
# Clock Stop and Enable Controller

This block sits between the dividers of a multi-output clock generator and its output pins. It decides, for every output, whether the clock runs, is held low, is parked in its stopped state or is released to high impedance. Three active-low pins drive that decision: power-down, CPU stop and PCI stop. Configuration bits from a register file refine it: per-output enables, per-pair immunity to CPU stop, per-output eligibility of the free-running PCI clocks for PCI stop, a register-driven PCI stop and a choice of CPU pair state during power-down.

The decision logic is combinational. It produces one request per output. Each request crosses into the domain of the clock it gates through a two-flop synchronizer, and the gate switches only at a safe point of that clock. Single-ended outputs therefore never shorten a high phase. Differential pairs change only on the rising edge of their source clock, so the true leg parks high and the complement leg parks low. The block also drives an oscillator enable and reports the current level of the CPU stop pin back to the register file.

Top module: `clk_stop_ctl`

## Requirements
- R1: While `rstN` is low, every single-ended output is low, every `cpuT` bit is 1, every `cpuC` bit is 0, and all of `cpuTOe`/`cpuCOe` are 0 (floated).
- R2: While `pwrDnN` is 0, `v66Out`, `buf66Out`, `pciFOut`, `pciOut`, `usbOut` and `dotOut` stay low, and `oscEn` is 0. When `pwrDnN` is 1, `oscEn` is 1.
- R3: While `pwrDnN` is 0 and `cpuPdTri` is 0, each pair drives `cpuT` high (`cpuTOe`=1) and floats the complement (`cpuCOe`=0). When `cpuPdTri` is 1, both `cpuTOe` and `cpuCOe` are 0.
- R4: Power-down overrides both stop pins, every `cpuFreeRun` bit and every enable bit. No output toggles while `pwrDnN` is 0.
- R5: While `cpuStopN` is 0, CPU pair i parks with `cpuT[i]`=1, `cpuC[i]`=0 and both legs driven, unless `cpuFreeRun[i]` is 1, in which case it keeps running.
- R6: While `pciStopN` is 0, every `pciOut` bit stays low. `pciFOut[i]` stops low only when `pciFStopEn[i]` is 1 and otherwise keeps running.
- R7: `regPciStop`=1 stops `pciOut` exactly as the pin does and has no effect on `pciFOut`, even when every `pciFStopEn` bit is 1.
- R8: An enable bit of 0 (`cpuOe[i]`, `pciOe[i]`, `pciFOe[i]`, `usbOe`, `dotOe`) holds its output inactive whatever the stop pins do. Single-ended outputs are held low. A disabled CPU pair parks true-high and complement-low with both legs floated.
- R9: `v66Out` and `buf66Out` run whenever `pwrDnN` is 1, regardless of the stop pins.
- R10: A single-ended gate opens or closes only while its source clock is low, and a CPU pair changes state only at the rising edge of `cpuSrc`. No output ever produces a high pulse shorter than half its source period. A changed request takes effect within three source periods.
- R11: `cpuStopSts` equals the current level of `cpuStopN`.
- R12: With `pwrDnN` at 1, CPU stop does not affect PCI or PCI_F outputs, and PCI stop does not affect CPU pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuSrc | input | 1 | Source clock for the CPU pairs |
| v66Src | input | 1 | Source clock for the 66 MHz outputs |
| pciSrc | input | 1 | Source clock for the PCI and PCI_F outputs |
| usbSrc | input | 1 | Source clock for the USB and DOT outputs |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Power-down pin, active low |
| cpuStopN | input | 1 | CPU stop pin, active low |
| pciStopN | input | 1 | PCI stop pin, active low |
| cpuFreeRun | input | 3 | Bit i=1 makes CPU pair i immune to CPU stop |
| cpuPdTri | input | 1 | 1 floats both legs of every pair during power-down |
| cpuOe | input | 3 | Per-pair enable, 1 = enabled |
| pciOe | input | 7 | Per-output PCI enable, 1 = enabled |
| pciFOe | input | 3 | Per-output PCI_F enable, 1 = enabled |
| pciFStopEn | input | 3 | Bit i=1 makes PCI_F i stop with the PCI stop pin |
| usbOe | input | 1 | USB enable, 1 = enabled |
| dotOe | input | 1 | DOT enable, 1 = enabled |
| regPciStop | input | 1 | Register-driven PCI stop, 1 = stop PCI outputs |
| cpuT | output | 3 | Gated true legs of the CPU pairs |
| cpuC | output | 3 | Gated complement legs of the CPU pairs |
| cpuTOe | output | 3 | Drive enable of the true legs, 0 = floated |
| cpuCOe | output | 3 | Drive enable of the complement legs, 0 = floated |
| v66Out | output | 1 | Gated 66 MHz output |
| buf66Out | output | 1 | Gated buffered 66 MHz output |
| pciFOut | output | 3 | Gated free-running PCI clocks |
| pciOut | output | 7 | Gated PCI clocks |
| usbOut | output | 1 | Gated USB clock |
| dotOut | output | 1 | Gated DOT clock |
| oscEn | output | 1 | Oscillator and VCO enable |
| cpuStopSts | output | 1 | Current CPU stop pin level for the register file |

## Verification
The pin and configuration patterns are applied in a fixed order. First all outputs run with default settings. CPU stop is then applied with a mixed free-run mask, which separates stopped pairs from immune ones. PCI stop by pin is applied with a mixed PCI_F eligibility mask, and PCI stop by register with full eligibility; these two patterns tell the pin path apart from the register path. Sparse enable masks come next, followed by power-down with free-run bits set and then the three-state choice, which shows power-down overriding everything else. After each pattern, edges are counted on every output over a fixed window, parked levels and drive enables are sampled, and monitors on representative outputs flag any high pulse shorter than half a source period across every transition.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NumCpu  = 3;
  localparam int NumPciF = 3;
  localparam int NumPci  = 7;

  // Strobes from the decision logic to the gating datapath
  typedef struct packed {
    logic [NumCpu-1:0]  cpuRun;
    logic [NumCpu-1:0]  cpuTFlt;
    logic [NumCpu-1:0]  cpuCFlt;
    logic               v66Run;
    logic               buf66Run;
    logic [NumPciF-1:0] pciFRun;
    logic [NumPci-1:0]  pciRun;
    logic               usbRun;
    logic               dotRun;
  } gateReq_t;
endpackage

// File: rtl/csc_se_gate.sv
// Single-ended glitch-free gate: request synchronized on rising edges,
// enable updated on the falling edge so it only moves while the clock is low.
module csc_se_gate (
  input  logic srcClk,
  input  logic rstN,
  input  logic runReq,
  output logic gClk
);
  logic syncA, syncB, enLow;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= runReq;
      syncB <= syncA;
    end
  end

  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) enLow <= 1'b0;
    else       enLow <= syncB;
  end

  assign gClk = srcClk & enLow;

  // R10: a request held off for three falling edges leaves the high phase empty
  a_r10_stopped_low: assert property (@(negedge srcClk) disable iff (!rstN)
    (!runReq && $past(!runReq) && $past(!runReq, 2) && $past(!runReq, 3)) |-> !gClk);

  // R10: a request held on for three falling edges passes the full high phase
  a_r10_running_high: assert property (@(negedge srcClk) disable iff (!rstN)
    (runReq && $past(runReq) && $past(runReq, 2) && $past(runReq, 3) && $past(rstN, 3)) |-> gClk);
endmodule

// File: rtl/csc_diff_gate.sv
// Differential pair gate: switches only at the rising edge of the source,
// so the true leg parks high and the complement parks low without a sliver.
module csc_diff_gate (
  input  logic srcClk,
  input  logic rstN,
  input  logic runReq,
  input  logic tFltReq,
  input  logic cFltReq,
  output logic clkT,
  output logic clkC,
  output logic oeT,
  output logic oeC
);
  localparam int ReqW = 3;
  localparam logic [ReqW-1:0] ResetVal = 3'b110; // {tFlt, cFlt, run}

  logic [ReqW-1:0] syncA, syncB;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= ResetVal;
      syncB <= ResetVal;
    end else begin
      syncA <= {tFltReq, cFltReq, runReq};
      syncB <= syncA;
    end
  end

  assign clkT = syncB[0] ? srcClk  : 1'b1;
  assign clkC = syncB[0] ? ~srcClk : 1'b0;
  assign oeT  = ~syncB[2];
  assign oeC  = ~syncB[1];

  // R5: a pair stopped for three rising edges is parked true-high, complement-low
  a_r5_parked: assert property (@(posedge srcClk) disable iff (!rstN)
    (!runReq && $past(!runReq) && $past(!runReq, 2)) |-> (clkT && !clkC));

  // R10: a running pair follows the source just before each rising edge
  a_r10_pair_runs: assert property (@(posedge srcClk) disable iff (!rstN)
    (runReq && $past(runReq) && $past(runReq, 2) && $past(rstN, 2)) |-> (!clkT && clkC));

  // R3: a steady complement float request releases the complement leg
  a_r3_comp_floated: assert property (@(posedge srcClk) disable iff (!rstN)
    (cFltReq && $past(cFltReq) && $past(cFltReq, 2)) |-> !oeC);
endmodule

// File: rtl/csc_ctrl.sv
// Decision logic: pins and configuration bits to per-output strobes.
module csc_ctrl
  import csc_pkg::*;
(
  input  logic               pwrDnN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic [NumCpu-1:0]  cpuFreeRun,
  input  logic               cpuPdTri,
  input  logic [NumCpu-1:0]  cpuOe,
  input  logic [NumPci-1:0]  pciOe,
  input  logic [NumPciF-1:0] pciFOe,
  input  logic [NumPciF-1:0] pciFStopEn,
  input  logic               usbOe,
  input  logic               dotOe,
  input  logic               regPciStop,
  output gateReq_t           req,
  output logic               oscEn,
  output logic               cpuStopSts
);
  logic pd;
  logic pciStopAll;

  always_comb begin
    pd         = !pwrDnN;
    pciStopAll = !pciStopN || regPciStop;
    req        = '0;
    for (int i = 0; i < NumCpu; i++) begin
      req.cpuRun[i]  = !pd && cpuOe[i] && (cpuStopN || cpuFreeRun[i]);
      req.cpuTFlt[i] = pd ? cpuPdTri : !cpuOe[i];
      req.cpuCFlt[i] = pd ? 1'b1     : !cpuOe[i];
    end
    req.v66Run   = !pd;
    req.buf66Run = !pd;
    for (int i = 0; i < NumPciF; i++) begin
      // only the pin, never the register bit, can stop an eligible PCI_F
      req.pciFRun[i] = !pd && pciFOe[i] && !(!pciStopN && pciFStopEn[i]);
    end
    for (int i = 0; i < NumPci; i++) begin
      req.pciRun[i] = !pd && pciOe[i] && !pciStopAll;
    end
    req.usbRun = !pd && usbOe;
    req.dotRun = !pd && dotOe;
  end

  assign oscEn      = pwrDnN;
  assign cpuStopSts = cpuStopN;

  always_comb begin
    if (pwrDnN === 1'b0) begin
      // R4: nothing may be requested to run during power-down
      a_r4_pd_override: assert ((req.cpuRun == '0) && (req.pciRun == '0) && (req.pciFRun == '0)
                               && !req.v66Run && !req.buf66Run && !req.usbRun && !req.dotRun);
      // R3: complements always released during power-down
      a_r3_pd_comp: assert (req.cpuCFlt == '1);
    end
    if (regPciStop === 1'b1) begin
      // R7: register stop silences every PCI request
      a_r7_reg_stop: assert (req.pciRun == '0);
    end
    if (pwrDnN === 1'b1 && pciStopN === 1'b1) begin
      // R7: without the pin, PCI_F follows its enable only
      a_r7_pcif_pin_only: assert (req.pciFRun == pciFOe);
    end
  end
endmodule

// File: rtl/csc_path.sv
// Gating datapath: one glitch-free gate per output, each in its source domain.
module csc_path
  import csc_pkg::*;
(
  input  logic               cpuSrc,
  input  logic               v66Src,
  input  logic               pciSrc,
  input  logic               usbSrc,
  input  logic               rstN,
  input  gateReq_t           req,
  output logic [NumCpu-1:0]  cpuT,
  output logic [NumCpu-1:0]  cpuC,
  output logic [NumCpu-1:0]  cpuTOe,
  output logic [NumCpu-1:0]  cpuCOe,
  output logic               v66Out,
  output logic               buf66Out,
  output logic [NumPciF-1:0] pciFOut,
  output logic [NumPci-1:0]  pciOut,
  output logic               usbOut,
  output logic               dotOut
);
  for (genvar i = 0; i < NumCpu; i++) begin : gCpu
    csc_diff_gate uPair (
      .srcClk (cpuSrc),
      .rstN   (rstN),
      .runReq (req.cpuRun[i]),
      .tFltReq(req.cpuTFlt[i]),
      .cFltReq(req.cpuCFlt[i]),
      .clkT   (cpuT[i]),
      .clkC   (cpuC[i]),
      .oeT    (cpuTOe[i]),
      .oeC    (cpuCOe[i])
    );
  end

  csc_se_gate uV66   (.srcClk(v66Src), .rstN(rstN), .runReq(req.v66Run),   .gClk(v66Out));
  csc_se_gate uBuf66 (.srcClk(v66Src), .rstN(rstN), .runReq(req.buf66Run), .gClk(buf66Out));

  for (genvar i = 0; i < NumPciF; i++) begin : gPciF
    csc_se_gate uGate (.srcClk(pciSrc), .rstN(rstN), .runReq(req.pciFRun[i]), .gClk(pciFOut[i]));
  end

  for (genvar i = 0; i < NumPci; i++) begin : gPci
    csc_se_gate uGate (.srcClk(pciSrc), .rstN(rstN), .runReq(req.pciRun[i]), .gClk(pciOut[i]));
  end

  csc_se_gate uUsb (.srcClk(usbSrc), .rstN(rstN), .runReq(req.usbRun), .gClk(usbOut));
  csc_se_gate uDot (.srcClk(usbSrc), .rstN(rstN), .runReq(req.dotRun), .gClk(dotOut));
endmodule

// File: rtl/clk_stop_ctl.sv
module clk_stop_ctl
  import csc_pkg::*;
(
  input  logic               cpuSrc,
  input  logic               v66Src,
  input  logic               pciSrc,
  input  logic               usbSrc,
  input  logic               rstN,
  input  logic               pwrDnN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic [NumCpu-1:0]  cpuFreeRun,
  input  logic               cpuPdTri,
  input  logic [NumCpu-1:0]  cpuOe,
  input  logic [NumPci-1:0]  pciOe,
  input  logic [NumPciF-1:0] pciFOe,
  input  logic [NumPciF-1:0] pciFStopEn,
  input  logic               usbOe,
  input  logic               dotOe,
  input  logic               regPciStop,
  output logic [NumCpu-1:0]  cpuT,
  output logic [NumCpu-1:0]  cpuC,
  output logic [NumCpu-1:0]  cpuTOe,
  output logic [NumCpu-1:0]  cpuCOe,
  output logic               v66Out,
  output logic               buf66Out,
  output logic [NumPciF-1:0] pciFOut,
  output logic [NumPci-1:0]  pciOut,
  output logic               usbOut,
  output logic               dotOut,
  output logic               oscEn,
  output logic               cpuStopSts
);
  gateReq_t req;

  csc_ctrl uCtrl (
    .pwrDnN    (pwrDnN),
    .cpuStopN  (cpuStopN),
    .pciStopN  (pciStopN),
    .cpuFreeRun(cpuFreeRun),
    .cpuPdTri  (cpuPdTri),
    .cpuOe     (cpuOe),
    .pciOe     (pciOe),
    .pciFOe    (pciFOe),
    .pciFStopEn(pciFStopEn),
    .usbOe     (usbOe),
    .dotOe     (dotOe),
    .regPciStop(regPciStop),
    .req       (req),
    .oscEn     (oscEn),
    .cpuStopSts(cpuStopSts)
  );

  csc_path uPath (
    .cpuSrc  (cpuSrc),
    .v66Src  (v66Src),
    .pciSrc  (pciSrc),
    .usbSrc  (usbSrc),
    .rstN    (rstN),
    .req     (req),
    .cpuT    (cpuT),
    .cpuC    (cpuC),
    .cpuTOe  (cpuTOe),
    .cpuCOe  (cpuCOe),
    .v66Out  (v66Out),
    .buf66Out(buf66Out),
    .pciFOut (pciFOut),
    .pciOut  (pciOut),
    .usbOut  (usbOut),
    .dotOut  (dotOut)
  );
endmodule

// File: tb/sim_clk_stop_ctl.sv
`timescale 1ns/1ps

module pulse_mon #(parameter real MinW = 1.0) (
  input  logic sig,
  output int   narrow
);
  realtime tRise;
  initial begin
    narrow = 0;
    tRise  = -1.0;
  end
  always @(posedge sig) tRise = $realtime;
  always @(negedge sig) begin
    if (tRise >= 0.0 && ($realtime - tRise) < MinW) narrow = narrow + 1;
  end
endmodule

module sim_clk_stop_ctl;
  import csc_pkg::*;

  logic cpuSrc = 1'b0, v66Src = 1'b0, pciSrc = 1'b0, usbSrc = 1'b0;
  logic rstN = 1'b1;
  logic pwrDnN, cpuStopN, pciStopN, cpuPdTri, usbOe, dotOe, regPciStop;
  logic [NumCpu-1:0]  cpuFreeRun, cpuOe;
  logic [NumPci-1:0]  pciOe;
  logic [NumPciF-1:0] pciFOe, pciFStopEn;
  logic [NumCpu-1:0]  cpuT, cpuC, cpuTOe, cpuCOe;
  logic v66Out, buf66Out, usbOut, dotOut, oscEn, cpuStopSts;
  logic [NumPciF-1:0] pciFOut;
  logic [NumPci-1:0]  pciOut;

  always #2.5  cpuSrc = ~cpuSrc;   // 200 MHz
  always #7.5  v66Src = ~v66Src;
  always #15.0 pciSrc = ~pciSrc;
  always #10.5 usbSrc = ~usbSrc;

  clk_stop_ctl u0 (.*);

  int nVec = 0, nBad = 0, cyc = 0;
  int cpuTCnt[NumCpu], cpuCCnt[NumCpu], pciFCnt[NumPciF], pciCnt[NumPci];
  int v66Cnt, bufCnt, usbCnt, dotCnt;
  int nz[6];

  for (genvar g = 0; g < NumCpu; g++) begin : gCc
    always @(posedge cpuT[g]) cpuTCnt[g] = cpuTCnt[g] + 1;
    always @(posedge cpuC[g]) cpuCCnt[g] = cpuCCnt[g] + 1;
  end
  for (genvar g = 0; g < NumPciF; g++) begin : gFc
    always @(posedge pciFOut[g]) pciFCnt[g] = pciFCnt[g] + 1;
  end
  for (genvar g = 0; g < NumPci; g++) begin : gPc
    always @(posedge pciOut[g]) pciCnt[g] = pciCnt[g] + 1;
  end
  always @(posedge v66Out)   v66Cnt = v66Cnt + 1;
  always @(posedge buf66Out) bufCnt = bufCnt + 1;
  always @(posedge usbOut)   usbCnt = usbCnt + 1;
  always @(posedge dotOut)   dotCnt = dotCnt + 1;

  // R10 monitors: high pulses no shorter than (almost) half the source period
  pulse_mon #(.MinW(2.3))  m0 (.sig(cpuT[0]),    .narrow(nz[0]));
  pulse_mon #(.MinW(2.3))  m1 (.sig(cpuC[0]),    .narrow(nz[1]));
  pulse_mon #(.MinW(14.5)) m2 (.sig(pciOut[0]),  .narrow(nz[2]));
  pulse_mon #(.MinW(14.5)) m3 (.sig(pciFOut[2]), .narrow(nz[3]));
  pulse_mon #(.MinW(7.0))  m4 (.sig(v66Out),     .narrow(nz[4]));
  pulse_mon #(.MinW(10.0)) m5 (.sig(usbOut),     .narrow(nz[5]));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  always @(posedge cpuSrc) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      nVec = nVec + 1;
      nBad = nBad + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nVec = nVec + 1;
    if (!ok) begin
      nBad = nBad + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // running: at least 5 rising edges in the window; stopped: none
  task automatic runChk(input string tag, input string what, input int cnt, input bit run);
    chk(run ? (cnt >= 5) : (cnt == 0), tag, what, cnt, run ? 5 : 0);
  endtask

  task automatic defaults();
    pwrDnN = 1; cpuStopN = 1; pciStopN = 1; cpuPdTri = 0; usbOe = 1; dotOe = 1;
    regPciStop = 0; cpuFreeRun = '0; cpuOe = '1; pciOe = '1; pciFOe = '1; pciFStopEn = '0;
  endtask

  task automatic measure();
    #250;
    for (int i = 0; i < NumCpu; i++) begin cpuTCnt[i] = 0; cpuCCnt[i] = 0; end
    for (int i = 0; i < NumPciF; i++) pciFCnt[i] = 0;
    for (int i = 0; i < NumPci; i++) pciCnt[i] = 0;
    v66Cnt = 0; bufCnt = 0; usbCnt = 0; dotCnt = 0;
    #300;
  endtask

  task automatic t_reset();
    defaults();
    #1 rstN = 0;
    #20;
    chk(pciOut == '0 && pciFOut == '0, "R1", "pci under reset", int'({pciOut, pciFOut}), 0);
    chk(!v66Out && !buf66Out && !usbOut && !dotOut, "R1", "66/usb/dot under reset",
        int'({v66Out, buf66Out, usbOut, dotOut}), 0);
    chk(cpuT == '1 && cpuC == '0, "R1", "cpu levels under reset", int'({cpuT, cpuC}), 8'b111000);
    chk(cpuTOe == '0 && cpuCOe == '0, "R1", "cpu drive under reset", int'({cpuTOe, cpuCOe}), 0);
    #13 rstN = 1;
  endtask

  task automatic t_normal();
    defaults();
    measure();
    for (int i = 0; i < NumCpu; i++) runChk("R10", "cpu pair runs", cpuTCnt[i], 1);
    for (int i = 0; i < NumPci; i++) runChk("R10", "pci runs", pciCnt[i], 1);
    for (int i = 0; i < NumPciF; i++) runChk("R10", "pcif runs", pciFCnt[i], 1);
    runChk("R9", "v66 runs", v66Cnt, 1);
    runChk("R9", "buf66 runs", bufCnt, 1);
    runChk("R8", "usb runs", usbCnt, 1);
    runChk("R8", "dot runs", dotCnt, 1);
    chk(cpuTOe == '1 && cpuCOe == '1, "R8", "enabled pairs driven", int'({cpuTOe, cpuCOe}), 63);
    chk(oscEn == 1, "R2", "oscEn when up", oscEn, 1);
    chk(cpuStopSts == 1, "R11", "status pin high", cpuStopSts, 1);
  endtask

  task automatic t_cpu_stop();
    defaults();
    cpuStopN = 0; cpuFreeRun = 3'b010;
    measure();
    runChk("R5", "pair0 stopped", cpuTCnt[0] + cpuCCnt[0], 0);
    runChk("R5", "pair1 free-running", cpuTCnt[1], 1);
    runChk("R5", "pair2 stopped", cpuTCnt[2] + cpuCCnt[2], 0);
    chk(cpuT[0] && !cpuC[0] && cpuT[2] && !cpuC[2], "R5", "parked levels",
        int'({cpuT[2], cpuC[2], cpuT[0], cpuC[0]}), 4'b1010);
    chk(cpuTOe == '1 && cpuCOe == '1, "R5", "stopped pairs driven", int'({cpuTOe, cpuCOe}), 63);
    runChk("R12", "pci unaffected by cpu stop", pciCnt[3], 1);
    runChk("R12", "pcif unaffected by cpu stop", pciFCnt[1], 1);
    chk(cpuStopSts == 0, "R11", "status pin low", cpuStopSts, 0);
  endtask

  task automatic t_pci_stop();
    defaults();
    pciStopN = 0; pciFStopEn = 3'b100;
    measure();
    for (int i = 0; i < NumPci; i++) runChk("R6", "pci stopped by pin", pciCnt[i], 0);
    chk(pciOut == '0, "R6", "pci parked low", int'(pciOut), 0);
    runChk("R6", "pcif0 ineligible runs", pciFCnt[0], 1);
    runChk("R6", "pcif1 ineligible runs", pciFCnt[1], 1);
    runChk("R6", "pcif2 eligible stops", pciFCnt[2], 0);
    runChk("R12", "cpu unaffected by pci stop", cpuTCnt[0], 1);
    runChk("R9", "v66 ignores stops", v66Cnt, 1);
    runChk("R9", "buf66 ignores stops", bufCnt, 1);
  endtask

  task automatic t_reg_stop();
    defaults();
    regPciStop = 1; pciFStopEn = 3'b111;
    measure();
    for (int i = 0; i < NumPci; i++) runChk("R7", "pci stopped by register", pciCnt[i], 0);
    for (int i = 0; i < NumPciF; i++) runChk("R7", "pcif ignores register stop", pciFCnt[i], 1);
  endtask

  task automatic t_enables();
    defaults();
    pciOe = 7'b1010101; pciFOe = 3'b011; usbOe = 0; cpuOe = 3'b101; cpuFreeRun = '1;
    measure();
    for (int i = 0; i < NumPci; i++) runChk("R8", "pci enable mask", pciCnt[i], pciOe[i]);
    for (int i = 0; i < NumPciF; i++) runChk("R8", "pcif enable mask", pciFCnt[i], pciFOe[i]);
    runChk("R8", "usb disabled", usbCnt, 0);
    runChk("R8", "dot enabled", dotCnt, 1);
    runChk("R8", "pair1 disabled", cpuTCnt[1] + cpuCCnt[1], 0);
    chk(cpuTOe[1] == 0 && cpuCOe[1] == 0, "R8", "pair1 floated", int'({cpuTOe[1], cpuCOe[1]}), 0);
    chk(cpuT[1] == 1 && cpuC[1] == 0, "R8", "pair1 parked", int'({cpuT[1], cpuC[1]}), 2);
    // disabled outputs stay quiet when a stop pin is also released and re-applied
    pciStopN = 0;
    measure();
    runChk("R8", "disabled pci1 under stop", pciCnt[1], 0);
    runChk("R8", "disabled pcif2 under stop", pciFCnt[2], 0);
  endtask

  task automatic t_pd();
    defaults();
    pwrDnN = 0; cpuFreeRun = '1; cpuPdTri = 0;
    measure();
    for (int i = 0; i < NumPci; i++) runChk("R2", "pci low in power-down", pciCnt[i], 0);
    for (int i = 0; i < NumPciF; i++) runChk("R2", "pcif low in power-down", pciFCnt[i], 0);
    runChk("R2", "v66 low in power-down", v66Cnt + bufCnt, 0);
    runChk("R2", "usb/dot low in power-down", usbCnt + dotCnt, 0);
    chk(oscEn == 0, "R2", "oscEn in power-down", oscEn, 0);
    for (int i = 0; i < NumCpu; i++) runChk("R4", "free-run pair still stops", cpuTCnt[i] + cpuCCnt[i], 0);
    chk(cpuT == '1, "R3", "true legs high", int'(cpuT), 7);
    chk(cpuTOe == '1 && cpuCOe == '0, "R3", "true driven, comp floated", int'({cpuTOe, cpuCOe}), 56);
    cpuPdTri = 1;
    measure();
    chk(cpuTOe == '0 && cpuCOe == '0, "R3", "both legs floated", int'({cpuTOe, cpuCOe}), 0);
    runChk("R4", "pd beats enables", v66Cnt + pciCnt[0], 0);
  endtask

  task automatic t_resume();
    defaults();
    measure();
    runChk("R4", "pair0 resumes", cpuTCnt[0], 1);
    runChk("R4", "pci resumes", pciCnt[6], 1);
    runChk("R4", "usb resumes", usbCnt, 1);
    chk(cpuTOe == '1 && cpuCOe == '1, "R4", "drive restored", int'({cpuTOe, cpuCOe}), 63);
    for (int i = 0; i < 6; i++) chk(nz[i] == 0, "R10", "narrow high pulses", nz[i], 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_cpu_stop();
    t_pci_stop();
    t_reg_stop();
    t_enables();
    t_pd();
    t_resume();
    summary();
  end
endmodule